// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Offset Trim

This block is the digital side of one column converter in a column-parallel image sensor readout. A convert strobe starts a binary search over a 12-bit code. In each search cycle the block drives a trial code to an external DAC. It then reads one comparator bit that reports whether the sampled input is at or above that trial level. The code is resolved most significant bit first.

A per-column offset register trims the comparator offset. In calibration mode the block converts a zero-reference input, the surrounding circuit having switched the sampler to that reference, and stores the resulting code as the offset. In normal mode the block subtracts the stored offset from the raw code and clamps the difference at zero. It then presents the 12-bit result with a single-cycle done strobe, so the line memory can capture it. The whole search is twelve cycles, which is short enough for sampling, gain and conversion to share one row period.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done` and `cal_done` are 0, and `result` and `dac_code` are 0.
- R2: A `conv_start` seen while idle raises `busy` in the next cycle with `dac_code` = 12'h800. `cal_mode` is sampled in that same cycle. While not busy, `dac_code` is 0.
- R3: In each search cycle the bit under test is kept when `cmp_hi` is 1 and cleared when it is 0, and the next lower bit is set as the new trial. For an ideal comparator, the raw code equals min(input, 4095).
- R4: A search lasts exactly 12 busy cycles. In the cycle `busy` falls, exactly one of `done` (normal) or `cal_done` (calibration) is high, for that one cycle only.
- R5: A `conv_start` that arrives while `busy` is high is ignored. The running search keeps its timing, its mode and its trial sequence.
- R6: A normal conversion reports `result` = raw code minus the stored offset, clamped to 0 when the difference would be negative.
- R7: A calibration conversion stores the raw code as the new offset. It pulses `cal_done` and not `done`, and leaves `result` unchanged.
- R8: `result` changes only in a cycle in which `done` is high, and holds its value between normal conversions.
- R9: After reset the stored offset is 0, so normal results equal the raw code until a calibration is run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Request to begin a conversion |
| cal_mode | input | 1 | 1 = calibration conversion, sampled with the start |
| cmp_hi | input | 1 | Comparator: sampled input is at or above the DAC level |
| dac_code | output | 12 | Trial code to the DAC |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle strobe: normal result valid |
| cal_done | output | 1 | One-cycle strobe: offset captured |
| result | output | 12 | Offset-corrected conversion code |

## Verification
On every cycle the assertions check the search framing, which covers:
- the first trial code;
- the zero DAC code while idle;
- the twelve-cycle search length and the limit that stops a second start from stretching it;
- the single end strobe whose kind depends on the mode;
- the rule that `result` moves only on `done`.

Only the bench scenarios can show that the values are correct. It replays the trial sequence bit by bit against a comparator model with an injected offset. It checks the subtraction after calibration, the clamp at zero when the stored offset is stale, and that a calibration leaves the last result untouched.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
    typedef enum logic [0:0] {
        PH_IDLE   = 1'b0,
        PH_SEARCH = 1'b1
    } phase_e;
endpackage

// File: rtl/sar_bit_step.sv
// One decision of the binary search: resolve the bit under test, then
// raise the next lower bit as the following trial.
module sar_bit_step #(
    parameter int W = 12
) (
    input  logic [W-1:0] code_i,
    input  logic [W-1:0] mask_i,
    input  logic         cmp_hi_i,
    output logic [W-1:0] code_o,
    output logic [W-1:0] mask_o,
    output logic         last_o
);
    logic [W-1:0] kept;

    always_comb begin
        kept   = cmp_hi_i ? code_i : (code_i & ~mask_i);
        mask_o = mask_i >> 1;
        code_o = kept | mask_o;
        last_o = mask_i[0];
    end
endmodule

// File: rtl/sar_offset_sub.sv
// Raw code minus offset; SATURATE selects clamping at zero or wrap.
module sar_offset_sub #(
    parameter int W        = 12,
    parameter bit SATURATE = 1'b1
) (
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] offset_i,
    output logic [W-1:0] corr_o
);
    logic [W:0] diff;

    always_comb diff = {1'b0, raw_i} - {1'b0, offset_i};

    generate
        if (SATURATE) begin : g_clamp
            always_comb corr_o = diff[W] ? '0 : diff[W-1:0];
        end else begin : g_wrap
            always_comb corr_o = diff[W-1:0];
        end
    endgenerate
endmodule

// File: rtl/sar_cal_reg.sv
// Per-column offset store, loaded at the end of a calibration search.
module sar_cal_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] off_d, off_q;

    always_comb begin
        off_d = off_q;
        if (load_i) off_d = din_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= off_d;
    end

    assign q_o = off_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_start,
    input  logic         cal_mode,
    input  logic         cmp_hi,
    output logic [W-1:0] dac_code,
    output logic         busy,
    output logic         done,
    output logic         cal_done,
    output logic [W-1:0] result
);
    import sar_ctrl_pkg::*;

    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        phase_e       phase;
        logic         cal;
        logic [W-1:0] code;
        logic [W-1:0] mask;
        logic         done;
        logic         cal_done;
        logic [W-1:0] result;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [W-1:0] step_code, step_mask, corr, offset_q;
    logic         step_last, cal_load;

    sar_bit_step #(.W(W)) u_step (
        .code_i   (ctl_q.code),
        .mask_i   (ctl_q.mask),
        .cmp_hi_i (cmp_hi),
        .code_o   (step_code),
        .mask_o   (step_mask),
        .last_o   (step_last)
    );

    sar_offset_sub #(.W(W), .SATURATE(1'b1)) u_sub (
        .raw_i    (step_code),
        .offset_i (offset_q),
        .corr_o   (corr)
    );

    sar_cal_reg #(.W(W)) u_cal (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cal_load),
        .din_i  (step_code),
        .q_o    (offset_q)
    );

    always_comb begin
        cal_load = (ctl_q.phase == PH_SEARCH) && step_last && ctl_q.cal;
    end

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.done     = 1'b0;
        ctl_d.cal_done = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (conv_start) begin
                    ctl_d.phase = PH_SEARCH;
                    ctl_d.cal   = cal_mode;
                    ctl_d.code  = TOP_BIT;
                    ctl_d.mask  = TOP_BIT;
                end
            end
            PH_SEARCH: begin
                ctl_d.code = step_code;
                ctl_d.mask = step_mask;
                if (step_last) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.code  = '0;
                    ctl_d.mask  = '0;
                    if (ctl_q.cal) begin
                        ctl_d.cal_done = 1'b1;
                    end else begin
                        ctl_d.done   = 1'b1;
                        ctl_d.result = corr;
                    end
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.phase    <= PH_IDLE;
            ctl_q.cal      <= 1'b0;
            ctl_q.code     <= '0;
            ctl_q.mask     <= '0;
            ctl_q.done     <= 1'b0;
            ctl_q.cal_done <= 1'b0;
            ctl_q.result   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dac_code = ctl_q.code;
    assign busy     = (ctl_q.phase == PH_SEARCH);
    assign done     = ctl_q.done;
    assign cal_done = ctl_q.cal_done;
    assign result   = ctl_q.result;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         conv_start,
    input logic [W-1:0] dac_code,
    input logic         busy,
    input logic         done,
    input logic         cal_done,
    input logic [W-1:0] result
);
    localparam int CW = $clog2(W + 1) + 1;
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> dac_code == TOP_BIT); // R2
    AST_DAC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> dac_code == '0); // R2
    AST_SEARCH_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (done || cal_done) |-> busy_cnt == CW'(W)); // R4
    AST_END_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || cal_done)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && cal_done)); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_start) |-> busy_cnt < CW'(W)); // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done); // R8
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .dac_code   (dac_code),
    .busy       (busy),
    .done       (done),
    .cal_done   (cal_done),
    .result     (result)
);

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 1'b0;
    logic cal_mode = 1'b0;
    logic cmp_hi;
    logic [W-1:0] dac_code, result;
    logic busy, done, cal_done;

    int checks = 0;
    int errors = 0;
    int vin = 0;       // analog input in LSB
    int cmp_off = 0;   // comparator offset in LSB
    int eff_in;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        eff_in = vin + cmp_off;
        if (eff_in > 4095) eff_in = 4095;
        if (eff_in < 0)    eff_in = 0;
    end
    assign cmp_hi = (eff_in >= int'(dac_code));

    sar_adc_ctrl #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cal_mode(cal_mode),
        .cmp_hi(cmp_hi), .dac_code(dac_code), .busy(busy), .done(done),
        .cal_done(cal_done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One conversion, started from idle. poke: second start while busy (R5).
    task automatic run_conv(input int in_lsb, input bit cal, input bit poke,
                            input int exp_res, input string tag);
        int acc = 0;
        bit trace_ok = 1'b1;
        int bad_dac = 0, bad_exp = 0;
        int prev_res;
        vin = in_lsb;
        prev_res = int'(result);
        @(negedge clk);
        conv_start = 1'b1;
        cal_mode   = cal;
        for (int k = 1; k <= W; k++) begin
            int trial;
            @(negedge clk);
            if (k == 1) begin
                chk(busy && dac_code == 12'h800, "R2", int'(dac_code), 2048);
            end
            if (poke && k == 5) begin
                conv_start = 1'b1;
                cal_mode   = ~cal;
            end else begin
                conv_start = 1'b0;
            end
            trial = acc | (1 << (W - k));
            if (int'(dac_code) != trial || !busy) begin
                if (trace_ok) begin bad_dac = int'(dac_code); bad_exp = trial; end
                trace_ok = 1'b0;
            end
            if (eff_in >= trial) acc = trial;
        end
        chk(trace_ok, {"R3 trace ", tag}, bad_dac, bad_exp);
        @(negedge clk);
        conv_start = 1'b0;
        chk(!busy && (done == !cal) && (cal_done == cal), {"R4 strobe ", tag},
            {busy, done, cal_done}, {1'b0, !cal, cal});
        if (cal) chk(int'(result) == prev_res, {"R7 result held ", tag}, int'(result), prev_res);
        else     chk(int'(result) == exp_res, {"R6 result ", tag}, int'(result), exp_res);
        @(negedge clk);
        chk(!done && !cal_done && !busy, {"R4 one-cycle ", tag}, {done, cal_done, busy}, 0);
        if (!cal) chk(int'(result) == exp_res, {"R8 hold ", tag}, int'(result), exp_res);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !cal_done && result == 0 && dac_code == 0,
            "R1 in reset", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !cal_done && result == 0 && dac_code == 0,
            "R1 after reset", int'(dac_code), 0);
    endtask

    task automatic test_plain();
        cmp_off = 0;
        run_conv(0,    1'b0, 1'b0, 0,    "R9 zero");
        run_conv(4095, 1'b0, 1'b0, 4095, "R9 full");
        run_conv(1234, 1'b0, 1'b0, 1234, "R9 mid");
        run_conv(2048, 1'b0, 1'b0, 2048, "R3 half");
        run_conv(2047, 1'b0, 1'b0, 2047, "R3 below half");
    endtask

    task automatic test_busy_start();
        cmp_off = 0;
        run_conv(777, 1'b0, 1'b1, 777, "R5 ignored start");
        // a poke that tried calibration must not have changed the offset
        run_conv(300, 1'b0, 1'b0, 300, "R5 offset untouched");
    endtask

    task automatic test_calibration();
        cmp_off = 37;
        run_conv(0,    1'b1, 1'b0, 0,    "R7 cal");
        run_conv(1000, 1'b0, 1'b0, 1000, "R6 corrected");
        run_conv(10,   1'b0, 1'b0, 10,   "R6 small");
        run_conv(4095, 1'b0, 1'b0, 4058, "R6 top clipped");
        cmp_off = 5;   // offset drifts, stale trim
        run_conv(10,   1'b0, 1'b0, 0,    "R6 clamp zero");
    endtask

    initial begin
        test_reset();
        test_plain();
        test_busy_start();
        test_calibration();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule